// File: doc/BRIEF.md
# ECC Control and Error Logging Unit

This unit is the supervisory side of a memory controller's error-correcting datapath. It does not compute or check codes itself. An external checker reports, once per checked read, whether it found a correctable single-bit error or an uncorrectable multi-bit error, and which chip-select the read went to. The unit interprets a software-programmed mode word and drives the datapath controls: check enable, correction enable, a write-back (scrub) request, and a control that forces the stored check byte to zero on every write.

Each error class is logged once. The first error of a class sets a sticky status bit and freezes the chip-select of that error. Later errors of the same class are neither logged nor reported until software clears the bit by writing a one to it. A newly logged error can raise a one-cycle system-error pulse. Each class has its own enable for this pulse, and a global enable input gates both classes.

Top module: `ecc_guard`

## Requirements
- R1: After reset the control word reads 0, both captured chip-selects read 0, and correctEn, checkEn, checkByteZero, serrPulse and scrubReq are all low.
- R2: The mode field is control-word bits 11:10 (00 off, 01 detect-only, 10 correct, 11 correct-and-scrub). checkEn is high for every mode except 00. correctEn is high for modes 10 and 11 while diagnostic mode is off.
- R3: In mode 00, error pulses from the checker set no status, capture no chip-select, and raise neither serrPulse nor scrubReq.
- R4: With checking on, the first single-bit error sets status bit 9 and the first multi-bit error sets status bit 8. The chip-select of each is captured in the log word (address 1): the single-bit chip-select in bits 2:0 and the multi-bit chip-select in bits 10:8.
- R5: While a class's status bit is set, further errors of that class leave its status bit and captured chip-select unchanged and raise no serrPulse.
- R6: A control-word write clears status bit 9 or 8 where the written data has a 1 in that bit. A 0 written to a status bit leaves it unchanged.
- R7: serrPulse is high for exactly the one cycle after a newly logged error, and only when busSerrEn is high and that class's enable is set. The single-bit enable is bit 15 and the multi-bit enable is bit 14.
- R8: Diagnostic mode (bit 12) drives checkByteZero high and forces correctEn low. In this mode errors are still logged and reported.
- R9: scrubReq pulses for one cycle after a single-bit error, and only in mode 11 with diagnostic mode off. Whether the error is logged does not matter. A multi-bit error never raises scrubReq.
- R10: Bits 31:16 and bit 13 of the control word read 0 whatever is written to them. The log word at address 1 is read-only, and writes to it change nothing.
- R11: When both classes report in the same cycle, both status bits are set. The two captured chip-selects are held separately, so clearing and re-logging one class leaves the other's chip-select unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 = control/status word, 1 = chip-select log |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the selected register (combinational) |
| errSingle | input | 1 | Checker flagged a single-bit error on this read |
| errMulti | input | 1 | Checker flagged a multi-bit error on this read |
| errCs | input | CS_W | Chip-select of the read being reported |
| busSerrEn | input | 1 | Global system-error enable from the bus command register |
| checkEn | output | 1 | Datapath should check read data |
| correctEn | output | 1 | Datapath should correct read data |
| checkByteZero | output | 1 | Datapath should write 0x00 as the check byte |
| scrubReq | output | 1 | One-cycle request to write corrected data back |
| serrPulse | output | 1 | One-cycle system-error pulse |

## Verification
The bench sweeps every combination of mode, diagnostic bit, both per-class enables and the global enable. For each combination it injects each error class twice, because the second injection must be silently dropped. A design that kept logging after the first error would overwrite the frozen chip-select or pulse system-error again. A design that skipped the global or per-class gating would pulse where the sweep expects none. Two further groups of checks catch a scrub raised for multi-bit errors or in diagnostic mode, and correction left active under diagnostic mode. Directed cases cover clear-by-one against write-zero, simultaneous errors of both classes, and reserved and read-only bits that must not hold written values.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_DETECT  = 2'b01,
    MODE_CORRECT = 2'b10,
    MODE_SCRUB   = 2'b11
  } eccMode_e;

  localparam int REG_W     = 32;
  localparam int STAT_LSB  = 8;   // bit 8 multi, bit 9 single
  localparam int MODE_LSB  = 10;
  localparam int DIAG_BIT  = 12;
  localparam int SERR_LSB  = 14;  // bit 14 multi, bit 15 single
  localparam int LOG_M_LSB = 8;   // multi-bit chip-select field in log word

  // class index: 0 = multi-bit, 1 = single-bit
  localparam int CLS_MULTI  = 0;
  localparam int CLS_SINGLE = 1;

  typedef struct packed {
    logic       checkOn;
    logic       scrubOn;
    logic [1:0] clrStat;   // write-one-to-clear per class
    logic [1:0] serrEn;    // per-class system-error enable
  } logStrobe_t;

endpackage

// File: rtl/ecc_guard_ctrl.sv
module ecc_guard_ctrl
  import ecc_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  output eccMode_e         cfgMode,
  output logic             cfgDiag,
  output logic [1:0]       cfgSerrEn,
  output logic             checkEn,
  output logic             correctEn,
  output logic             checkByteZero,
  output logic             scrubOn,
  output logStrobe_t       strobe
);

  logic ctlWrite;
  assign ctlWrite = regWrEn && !regAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgMode   <= MODE_OFF;
      cfgDiag   <= 1'b0;
      cfgSerrEn <= 2'b00;
    end else if (ctlWrite) begin
      cfgMode   <= eccMode_e'(regWrData[MODE_LSB +: 2]);
      cfgDiag   <= regWrData[DIAG_BIT];
      cfgSerrEn <= regWrData[SERR_LSB +: 2];
    end
  end

  always_comb begin
    checkEn       = (cfgMode != MODE_OFF);
    correctEn     = (cfgMode == MODE_CORRECT || cfgMode == MODE_SCRUB) && !cfgDiag;
    checkByteZero = cfgDiag;
    scrubOn       = (cfgMode == MODE_SCRUB) && !cfgDiag;
  end

  always_comb begin
    strobe.checkOn = checkEn;
    strobe.scrubOn = scrubOn;
    strobe.serrEn  = cfgSerrEn;
    strobe.clrStat = ctlWrite ? regWrData[STAT_LSB +: 2] : 2'b00;
  end

endmodule

// File: rtl/ecc_guard_log.sv
module ecc_guard_log
  import ecc_guard_pkg::*;
#(
  parameter int CS_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logStrobe_t      strobe,
  input  logic            errSingle,
  input  logic            errMulti,
  input  logic [CS_W-1:0] errCs,
  input  logic            busSerrEn,
  output logic [1:0]      statBits,
  output logic [CS_W-1:0] csLog [2],
  output logic            serrPulse,
  output logic            scrubReq
);

  logic [1:0] errIn;
  logic [1:0] newErr;

  assign errIn = {errSingle, errMulti};

  for (genvar k = 0; k < 2; k++) begin : g_cls
    assign newErr[k] = errIn[k] && strobe.checkOn && !statBits[k];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statBits[k] <= 1'b0;
        csLog[k]    <= '0;
      end else begin
        statBits[k] <= (statBits[k] && !strobe.clrStat[k]) || newErr[k];
        if (newErr[k]) csLog[k] <= errCs;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serrPulse <= 1'b0;
      scrubReq  <= 1'b0;
    end else begin
      serrPulse <= busSerrEn && |(newErr & strobe.serrEn);
      scrubReq  <= errSingle && strobe.scrubOn;
    end
  end

endmodule

// File: rtl/ecc_guard.sv
module ecc_guard
  import ecc_guard_pkg::*;
#(
  parameter int CS_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic            regAddr,
  input  logic [31:0]     regWrData,
  output logic [31:0]     regRdData,
  input  logic            errSingle,
  input  logic            errMulti,
  input  logic [CS_W-1:0] errCs,
  input  logic            busSerrEn,
  output logic            checkEn,
  output logic            correctEn,
  output logic            checkByteZero,
  output logic            scrubReq,
  output logic            serrPulse
);

  eccMode_e        cfgMode;
  logic            cfgDiag;
  logic [1:0]      cfgSerrEn;
  logic            scrubOn;
  logStrobe_t      strobe;
  logic [1:0]      statBits;
  logic [CS_W-1:0] csLog [2];

  ecc_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .cfgMode(cfgMode), .cfgDiag(cfgDiag),
    .cfgSerrEn(cfgSerrEn), .checkEn(checkEn), .correctEn(correctEn),
    .checkByteZero(checkByteZero), .scrubOn(scrubOn), .strobe(strobe)
  );

  ecc_guard_log #(.CS_W(CS_W)) u_log (
    .clk(clk), .rstN(rstN), .strobe(strobe), .errSingle(errSingle),
    .errMulti(errMulti), .errCs(errCs), .busSerrEn(busSerrEn),
    .statBits(statBits), .csLog(csLog), .serrPulse(serrPulse),
    .scrubReq(scrubReq)
  );

  always_comb begin
    regRdData = '0;
    if (!regAddr) begin
      regRdData[SERR_LSB +: 2] = cfgSerrEn;
      regRdData[DIAG_BIT]      = cfgDiag;
      regRdData[MODE_LSB +: 2] = cfgMode;
      regRdData[STAT_LSB +: 2] = statBits;
    end else begin
      regRdData[CS_W-1:0]         = csLog[CLS_SINGLE];
      regRdData[LOG_M_LSB +: CS_W] = csLog[CLS_MULTI];
    end
  end

endmodule

// File: rtl/ecc_guard_chk.sv
module ecc_guard_chk #(
  parameter int CS_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            regWrEn,
  input logic            regAddr,
  input logic [31:0]     regWrData,
  input logic [31:0]     regRdData,
  input logic            errSingle,
  input logic            errMulti,
  input logic            busSerrEn,
  input logic            correctEn,
  input logic            checkByteZero,
  input logic            checkEn,
  input logic            scrubReq,
  input logic            serrPulse,
  input logic [1:0]      statBits,
  input logic [1:0]      cfgMode,
  input logic [CS_W-1:0] csSingle,
  input logic [CS_W-1:0] csMulti
);

  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr |-> (regRdData[31:16] == 16'h0 && regRdData[13] == 1'b0));

  p_serr_global_r7: assert property (@(posedge clk) disable iff (!rstN)
    serrPulse |-> $past(busSerrEn));

  p_serr_new_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    serrPulse |-> $past((errSingle && !statBits[1]) || (errMulti && !statBits[0])));

  p_scrub_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    scrubReq |-> $past(errSingle && cfgMode == 2'b11 && correctEn));

  p_diag_no_correct_r8: assert property (@(posedge clk) disable iff (!rstN)
    checkByteZero |-> !correctEn);

  p_sticky_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statBits[1] && !(regWrEn && !regAddr && regWrData[9])) |=> statBits[1]);

  p_sticky_multi_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statBits[0] && !(regWrEn && !regAddr && regWrData[8])) |=> statBits[0]);

  p_cs_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statBits[1] && $past(statBits[1])) |-> $stable(csSingle));

  p_off_no_log_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!checkEn && !statBits[1]) |=> !statBits[1]);

endmodule

bind ecc_guard ecc_guard_chk #(.CS_W(CS_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .errSingle(errSingle),
  .errMulti(errMulti), .busSerrEn(busSerrEn), .correctEn(correctEn),
  .checkByteZero(checkByteZero), .checkEn(checkEn), .scrubReq(scrubReq),
  .serrPulse(serrPulse), .statBits(statBits), .cfgMode(cfgMode),
  .csSingle(csLog[1]), .csMulti(csLog[0])
);

// File: tb/ecc_guard_bench.sv
module ecc_guard_bench;

  localparam int CS_W = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            regWrEn = 1'b0;
  logic            regAddr = 1'b0;
  logic [31:0]     regWrData = '0;
  logic [31:0]     regRdData;
  logic            errSingle = 1'b0;
  logic            errMulti = 1'b0;
  logic [CS_W-1:0] errCs = '0;
  logic            busSerrEn = 1'b0;
  logic            checkEn, correctEn, checkByteZero, scrubReq, serrPulse;

  int errors = 0;
  int checks = 0;
  logic [CS_W-1:0] expCsS = '0, expCsM = '0;

  always #5 clk = ~clk;

  ecc_guard #(.CS_W(CS_W)) u_ecc_guard (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .errSingle(errSingle),
    .errMulti(errMulti), .errCs(errCs), .busSerrEn(busSerrEn),
    .checkEn(checkEn), .correctEn(correctEn), .checkByteZero(checkByteZero),
    .scrubReq(scrubReq), .serrPulse(serrPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 1'b0; regWrData = '0;
  endtask

  task automatic readReg(input logic a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
    regAddr = 1'b0;
    #1;
  endtask

  // drive one checker report for one cycle; on return the registered pulses are visible
  task automatic pulseErr(input logic s, input logic m, input logic [CS_W-1:0] cs);
    @(negedge clk);
    errSingle = s; errMulti = m; errCs = cs;
    @(negedge clk);
    errSingle = 1'b0; errMulti = 1'b0; errCs = '0;
  endtask

  function automatic logic [31:0] logWord();
    return {21'b0, expCsM, 5'b0, expCsS};
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] cfgWord;
    logic [1:0]  stat;
    logic        on;
    logic [CS_W-1:0] cs1, cs2;

    repeat (3) @(negedge clk);
    // R1: reset state
    readReg(1'b0, rd); check("R1 ctl word", rd, 32'h0);
    readReg(1'b1, rd); check("R1 log word", rd, 32'h0);
    check("R1 outputs", {27'b0, checkEn, correctEn, checkByteZero, serrPulse, scrubReq}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    // sweep mode x diag x per-class enables x global enable
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 4; s++)
          for (int g = 0; g < 2; g++) begin
            cfgWord = (s << 14) | (d << 12) | (m << 10) | (3 << 8);
            busSerrEn = g[0];
            writeReg(1'b0, cfgWord);
            on = (m != 0);
            check("R2 checkEn", {31'b0, checkEn}, {31'b0, on});
            check("R2/R8 correctEn", {31'b0, correctEn}, {31'b0, (m >= 2) && (d == 0)});
            check("R8 checkByteZero", {31'b0, checkByteZero}, d);
            readReg(1'b0, rd);
            check("R6 cleared ctl readback", rd, (s << 14) | (d << 12) | (m << 10));
            cs1 = CS_W'((m * 16 + d * 8 + s * 2 + g) % 8);
            cs2 = CS_W'((m * 16 + d * 8 + s * 2 + g + 3) % 8);

            pulseErr(1'b1, 1'b0, cs1);
            if (on) expCsS = cs1;
            check("R7 serr single", {31'b0, serrPulse}, {31'b0, on && s[1] && g[0]});
            check("R9 scrub single", {31'b0, scrubReq}, {31'b0, (m == 3) && (d == 0)});
            readReg(1'b0, rd);
            check("R3/R4 single status", rd[9:8], {on, 1'b0});
            readReg(1'b1, rd); check("R4 single cs", rd, logWord());

            pulseErr(1'b0, 1'b1, cs2);
            if (on) expCsM = cs2;
            check("R7 serr multi", {31'b0, serrPulse}, {31'b0, on && s[0] && g[0]});
            check("R9 no scrub multi", {31'b0, scrubReq}, 32'h0);
            readReg(1'b0, rd);
            check("R3/R4 multi status", rd[9:8], {on, on});
            readReg(1'b1, rd); check("R4 multi cs", rd, logWord());

            pulseErr(1'b1, 1'b0, cs2);
            check("R5 single suppressed", {31'b0, serrPulse}, 32'h0);
            check("R9 scrub unlogged", {31'b0, scrubReq}, {31'b0, (m == 3) && (d == 0)});
            pulseErr(1'b0, 1'b1, cs1);
            check("R5 multi suppressed", {31'b0, serrPulse}, 32'h0);
            readReg(1'b1, rd); check("R5 cs frozen", rd, logWord());
          end

    // R7: pulse lasts one cycle
    busSerrEn = 1'b1;
    writeReg(1'b0, 32'h0000_CB00);    // both enables, correct mode, clear status
    pulseErr(1'b1, 1'b0, 3'd1);
    check("R7 pulse high", {31'b0, serrPulse}, 32'h1);
    @(negedge clk);
    check("R7 pulse one cycle", {31'b0, serrPulse}, 32'h0);

    // R6: writing zeros keeps status, writing one clears only that bit
    pulseErr(1'b0, 1'b1, 3'd2);
    writeReg(1'b0, 32'h0000_C800);
    readReg(1'b0, rd); check("R6 write zero keeps", rd[9:8], 2'b11);
    writeReg(1'b0, 32'h0000_C900);
    readReg(1'b0, rd); check("R6 clear multi only", rd[9:8], 2'b10);

    // R11: simultaneous errors, separate capture
    writeReg(1'b0, 32'h0000_CB00);
    pulseErr(1'b1, 1'b1, 3'd5);
    expCsS = 3'd5; expCsM = 3'd5;
    check("R11 serr both", {31'b0, serrPulse}, 32'h1);
    readReg(1'b0, rd); check("R11 both status", rd[9:8], 2'b11);
    writeReg(1'b0, 32'h0000_C900);
    pulseErr(1'b0, 1'b1, 3'd2);
    expCsM = 3'd2;
    readReg(1'b1, rd); check("R11 separate cs", rd, logWord());

    // R10: reserved bits and read-only log word
    writeReg(1'b0, 32'hFFFF_FFFF);
    readReg(1'b0, rd); check("R10 reserved zero", rd, 32'h0000_DC00);
    writeReg(1'b1, 32'hFFFF_FFFF);
    readReg(1'b1, rd); check("R10 log read-only", rd, logWord());
    readReg(1'b0, rd); check("R10 ctl untouched", rd, 32'h0000_DC00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule